// File: doc/BRIEF.md
# Criticality-Aware Victim Selector

This block chooses which way of a set-associative cache to evict on a miss. Each line is either critical or ordinary, and the eviction policy protects the critical lines. The block keeps, for every set and every way, a valid bit, a critical flag and a recency age. When a miss arrives it names the victim way in the same cycle, with no clock edge in between. Tag and data arrays live outside the block. The surrounding cache uses the victim number to steer its own fill.

Software programs a small bank of address windows. Each window has an inclusive lower bound, an inclusive upper bound and an enable. When a miss fills a line, the block compares the miss address with the windows. The line is critical if the address falls inside any active window, and that result is stored with the line. A hit or a fill makes the accessed way the most recent one in its set.

On a miss the block picks the oldest ordinary line. If the set holds only ordinary lines, or only critical lines, it picks the plain oldest line instead. Empty ways are always used before any occupied way.

Top module: `crit_victim_sel`

## Requirements
- R1: After reset every way of every set is empty and every window is disabled. Successive misses to one set therefore fill ways 0, 1, 2, 3 in that order, and `addr_critical` reads 0 for any address.
- R2: While a set holds an empty way, the victim is the lowest-numbered empty way.
- R3: When all ways of a set are occupied and none is critical, the victim is the way with the largest age (the least recently used way).
- R4: When all ways of a set are occupied and all are critical, the victim is the least recently used way.
- R5: When all ways of a set are occupied and some, but not all, are critical, the victim is the least recently used way among the non-critical ones.
- R6: An access sets the age of its way to 0, the most recent value. Every other way in that set whose age was below the accessed way's old age gains 1. All other ages are unchanged, so the ages in a set always stay distinct. A hit uses `acc_way`. A miss uses the victim.
- R7: `addr_critical` is 1 exactly when `acc_addr` lies in some window whose enable is set and whose lower bound is at or below its upper bound. Both bounds are inclusive. A window with its enable clear, or with its lower bound above its upper bound, never matches.
- R8: A filled line's critical flag is the value `addr_critical` had in the miss cycle. Later window writes do not change it.
- R9: `victim_way` and `victim_valid` are combinational. `victim_valid` equals `acc_valid & ~acc_hit`. The set state changes only on the clock edge that ends an access cycle.
- R10: Each set keeps its own state. An access changes only the set named by `acc_set`.
- R11: A cycle with `cfg_we` high writes enable, lower bound and upper bound into the window selected by `cfg_sel`. The write takes effect on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_sel | input | 2 | Window number to write |
| cfg_en | input | 1 | Enable bit to write |
| cfg_lo | input | 32 | Inclusive lower bound to write |
| cfg_hi | input | 32 | Inclusive upper bound to write |
| acc_valid | input | 1 | Access strobe |
| acc_hit | input | 1 | 1 = hit on `acc_way`, 0 = miss |
| acc_set | input | 3 | Set index of the access |
| acc_way | input | 2 | Way that hit |
| acc_addr | input | 32 | Address of the access |
| victim_valid | output | 1 | A miss is being presented |
| victim_way | output | 2 | Way chosen for eviction |
| addr_critical | output | 1 | `acc_addr` lies in an active window |

## Verification
The assertions take for granted that a hit always names a way that is currently occupied. Some of them also rely on `acc_set` and `acc_way` holding steady through the cycle they are sampled in. The bench drives every input on the falling edge and issues hits only to ways its own model records as filled. Random addresses stay within a 256-byte region, so the window bounds drawn from the same range give a real mix of critical and ordinary lines. Window rewrites are spaced through the random sweep so that the "flag frozen at fill" rule is exercised.

// File: rtl/crit_victim_sel.sv
module crit_victim_sel #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  parameter int RANGES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(RANGES)-1:0] cfg_sel,
  input  logic                      cfg_en,
  input  logic [ADDR_W-1:0]         cfg_lo,
  input  logic [ADDR_W-1:0]         cfg_hi,
  input  logic                      acc_valid,
  input  logic                      acc_hit,
  input  logic [$clog2(SETS)-1:0]   acc_set,
  input  logic [$clog2(WAYS)-1:0]   acc_way,
  input  logic [ADDR_W-1:0]         acc_addr,
  output logic                      victim_valid,
  output logic [$clog2(WAYS)-1:0]   victim_way,
  output logic                      addr_critical
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int CNT_W = WAY_W + 1;
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [ADDR_W-1:0] win_lo [RANGES];
  logic [ADDR_W-1:0] win_hi [RANGES];
  logic [RANGES-1:0] win_en;
  logic [RANGES-1:0] win_hit;

  logic [WAY_W-1:0] age  [SETS][WAYS];
  logic [WAYS-1:0]  vld  [SETS];
  logic [WAYS-1:0]  crit [SETS];

  genvar r;
  generate
    for (r = 0; r < RANGES; r++) begin : g_win
      assign win_hit[r] = win_en[r] && (win_lo[r] <= win_hi[r]) &&
                          (acc_addr >= win_lo[r]) && (acc_addr <= win_hi[r]);
    end
  endgenerate

  assign addr_critical = |win_hit;
  assign victim_valid  = acc_valid & ~acc_hit;

  logic             have_empty, have_plain;
  logic [WAY_W-1:0] empty_way, lru_way, plain_way, plain_age;
  logic [CNT_W-1:0] n_crit;

  always_comb begin
    have_empty = 1'b0;
    have_plain = 1'b0;
    empty_way  = '0;
    lru_way    = '0;
    plain_way  = '0;
    plain_age  = '0;
    n_crit     = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vld[acc_set][w] && !have_empty) begin
        have_empty = 1'b1;
        empty_way  = WAY_W'(w);
      end
      if (age[acc_set][w] == OLDEST) lru_way = WAY_W'(w);
      if (crit[acc_set][w]) n_crit = n_crit + 1'b1;
      else if (!have_plain || age[acc_set][w] > plain_age) begin
        have_plain = 1'b1;
        plain_way  = WAY_W'(w);
        plain_age  = age[acc_set][w];
      end
    end
    if (have_empty)
      victim_way = empty_way;
    else if (n_crit == '0 || n_crit == CNT_W'(WAYS))
      victim_way = lru_way;
    else
      victim_way = plain_way;
  end

  logic [WAY_W-1:0] use_way;
  assign use_way = acc_hit ? acc_way : victim_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_en <= '0;
      for (int i = 0; i < RANGES; i++) begin
        win_lo[i] <= '0;
        win_hi[i] <= '0;
      end
      for (int s = 0; s < SETS; s++) begin
        vld[s]  <= '0;
        crit[s] <= '0;
        for (int w = 0; w < WAYS; w++) age[s][w] <= WAY_W'(w);
      end
    end else begin
      if (cfg_we) begin
        win_en[cfg_sel] <= cfg_en;
        win_lo[cfg_sel] <= cfg_lo;
        win_hi[cfg_sel] <= cfg_hi;
      end
      if (acc_valid) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == use_way)
            age[acc_set][w] <= '0;
          else if (age[acc_set][w] < age[acc_set][use_way])
            age[acc_set][w] <= age[acc_set][w] + 1'b1;
        end
        if (!acc_hit) begin
          vld[acc_set][use_way]  <= 1'b1;
          crit[acc_set][use_way] <= addr_critical;
        end
      end
    end
  end

  logic [WAYS-1:0] ages_seen;
  always_comb begin
    ages_seen = '0;
    for (int w = 0; w < WAYS; w++) ages_seen[age[acc_set][w]] = 1'b1;
  end

  a_r6_ages_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ages_seen) == WAYS);

  a_r6_accessed_newest: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> age[$past(acc_set)][$past(use_way)] == '0);

  a_r2_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_valid && !(&vld[acc_set])) |-> !vld[acc_set][victim_way]);

  a_r3_r4_plain_lru: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_valid && (&vld[acc_set]) && (crit[acc_set] == '0 || (&crit[acc_set])))
      |-> age[acc_set][victim_way] == OLDEST);

  a_r5_spare_critical: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_valid && (&vld[acc_set]) && crit[acc_set] != '0 && !(&crit[acc_set]))
      |-> !crit[acc_set][victim_way]);

  a_r8_flag_latched: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |=> crit[$past(acc_set)][$past(victim_way)] == $past(addr_critical));
endmodule

// File: tb/crit_victim_sel_test.sv
module crit_victim_sel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic        cfg_en = 1'b0;
  logic [31:0] cfg_lo = '0, cfg_hi = '0;
  logic        acc_valid = 1'b0, acc_hit = 1'b0;
  logic [2:0]  acc_set = '0;
  logic [1:0]  acc_way = '0;
  logic [31:0] acc_addr = '0;
  logic        victim_valid, addr_critical;
  logic [1:0]  victim_way;

  crit_victim_sel uut (.*);

  always #5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  int          m_age [8][4];
  bit          m_vld [8][4];
  bit          m_crit[8][4];
  bit          m_en  [4];
  logic [31:0] m_lo  [4];
  logic [31:0] m_hi  [4];

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit m_match(logic [31:0] a);
    for (int r = 0; r < 4; r++)
      if (m_en[r] && m_lo[r] <= m_hi[r] && a >= m_lo[r] && a <= m_hi[r]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int m_victim(int s);
    int nc = 0, lru = 0, best = -1, bage = -1;
    for (int w = 0; w < 4; w++) if (!m_vld[s][w]) return w;
    for (int w = 0; w < 4; w++) begin
      if (m_crit[s][w]) nc++;
      else if (m_age[s][w] > bage) begin best = w; bage = m_age[s][w]; end
      if (m_age[s][w] == 3) lru = w;
    end
    if (nc == 0 || nc == 4) return lru;
    return best;
  endfunction

  task automatic m_reset();
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 4; w++) begin
        m_age[s][w] = w; m_vld[s][w] = 0; m_crit[s][w] = 0;
      end
    for (int r = 0; r < 4; r++) begin m_en[r] = 0; m_lo[r] = 0; m_hi[r] = 0; end
  endtask

  task automatic write_win(int sel, bit en, logic [31:0] lo, logic [31:0] hi);
    @(negedge clk);
    acc_valid = 0; cfg_we = 1; cfg_sel = 2'(sel); cfg_en = en; cfg_lo = lo; cfg_hi = hi;
    @(posedge clk);
    m_en[sel] = en; m_lo[sel] = lo; m_hi[sel] = hi;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic probe(logic [31:0] a, string req);
    @(negedge clk);
    cfg_we = 0; acc_valid = 0; acc_addr = a;
    #1 check(req, addr_critical, m_match(a));
  endtask

  task automatic access(bit hit, int s, int w, logic [31:0] a, string req);
    int uw, old;
    bit cr;
    @(negedge clk);
    cfg_we = 0; acc_valid = 1; acc_hit = hit; acc_set = 3'(s); acc_way = 2'(w); acc_addr = a;
    #1;
    cr = m_match(a);
    check({req, " R7 addr_critical"}, addr_critical, cr);
    check("R9 victim_valid", victim_valid, !hit);
    uw = hit ? w : m_victim(s);
    if (!hit) check({req, " victim"}, victim_way, uw);
    @(posedge clk);
    old = m_age[s][uw];
    for (int k = 0; k < 4; k++)
      if (k == uw) m_age[s][k] = 0;
      else if (m_age[s][k] < old) m_age[s][k]++;
    if (!hit) begin m_vld[s][uw] = 1; m_crit[s][uw] = cr; end
    @(negedge clk);
    acc_valid = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    probe(32'h0, "R1 windows off");
    probe(32'hFFFF_FFFF, "R1 windows off");
    for (int w = 0; w < 4; w++) access(0, 0, 0, 32'h10, "R1 fill order");

    write_win(0, 1, 32'h1000, 32'h1FFF);
    write_win(1, 1, 32'h5000, 32'h4000);
    write_win(2, 0, 32'h0, 32'hFFFF_FFFF);
    probe(32'h0FFF, "R7 below lo");
    probe(32'h1000, "R7 at lo");
    probe(32'h1FFF, "R7 at hi");
    probe(32'h2000, "R7 above hi");
    probe(32'h4800, "R7 lo>hi");
    probe(32'h9000, "R7 disabled");
    write_win(3, 1, 32'h9000, 32'h9000);
    probe(32'h9000, "R11 write visible");

    access(0, 1, 0, 32'h1000, "R2 empty");
    access(0, 1, 0, 32'h3000, "R2 empty");
    access(0, 1, 0, 32'h3004, "R2 empty");
    access(0, 1, 0, 32'h3008, "R2 empty");
    write_win(0, 0, 32'h1000, 32'h1FFF);
    access(0, 1, 0, 32'h3010, "R8 R5 frozen flag");
    access(0, 1, 0, 32'h3014, "R5 mixed");

    for (int w = 0; w < 4; w++) access(0, 2, 0, 32'h3000 + 32'(w), "R2 fill");
    access(1, 2, 0, 32'h0, "R6 hit");
    access(0, 2, 0, 32'h3100, "R3 plain lru");
    write_win(0, 1, 32'h0, 32'hFFFF);
    for (int w = 0; w < 4; w++) access(0, 3, 0, 32'h20, "R2 fill");
    access(1, 3, 2, 32'h0, "R6 hit");
    access(0, 3, 0, 32'h24, "R4 all critical");
    access(0, 4, 0, 32'h0, "R10 untouched set");

    m_reset();
    @(negedge clk) rst_n = 0;
    @(posedge clk);
    @(negedge clk) rst_n = 1;
    lf = 32'hACE1_2345;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (i % 150 == 0)
        write_win(int'(lf[1:0]), lf[2], {24'h0, lf[15:8]}, {24'h0, lf[23:16]});
      else begin
        int s, w;
        bit h;
        s = int'(lf[6:4]);
        w = int'(lf[9:8]);
        h = lf[3] && m_vld[s][w];
        access(h, s, w, {24'h0, lf[31:24]}, "R3 R4 R5 R6 R10 sweep");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule